// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block sits in the feedback path of a tuner synthesizer loop. It counts cycles of the local-oscillator clock and emits a single-cycle pulse once per programmed division. That pulse goes to the phase detector. Two select inputs choose one of three paths:

- **High band:** a fixed halving stage feeds a dual-modulus swallow divider.
- **Mid band:** the oscillator drives the swallow divider directly.
- **Low band:** a plain 12-bit counter fed from the upper twelve bits of the divisor word.

The swallow divider splits the divisor into two parts. The low four bits are a swallow count. The upper twelve bits are a main count. Each main-count cycle spans 17 oscillator events while the swallow count is non-zero, and 16 events once it has run out.

A new divisor word or select setting is not applied at once. It is staged, and it is taken into use only after the second reference tick that follows the last change. The loop therefore keeps the old division for a full reference period. The period already in progress always finishes with the values it started with. An inhibit input parks the counters in their load state and keeps the output low.

Top module: `lo_feedback_divider`

## Requirements
- R1: With `hi_band_sel`=1 (whatever `swallow_sel` is), pulses are spaced by twice the divisor word in `lo_clk` cycles.
- R2: With `hi_band_sel`=0 and `swallow_sel`=1, pulses are spaced by exactly the divisor word in `lo_clk` cycles.
- R3: With both selects 0, pulses are spaced by `div_word[15:4]` cycles, and `div_word[3:0]` has no effect on the spacing.
- R4: In the swallow paths, a word with swallow part A=`div_word[3:0]` and main part M=`div_word[15:4]` divides by 16·M+A, including at A=0 and A=15.
- R5: A word below 272 in either swallow path divides as 272. A value of `div_word[15:4]` below 4 in the low band divides as 4.
- R6: A change of word or selects takes effect at the clock edge that samples the second `ref_tick` after the last change. The first tick leaves the old setting in use, and a further change restarts the wait.
- R7: A division period already under way when the setting changes completes with the old divisor. The new divisor applies from the next period.
- R8: `div_pulse` is high for exactly one cycle per division period and is never high on two consecutive cycles.
- R9: While `inhibit` is sampled high, `div_pulse` is low from the next cycle on. After release, the first pulse comes one full division period (in `lo_clk` cycles) after the first edge that samples `inhibit` low.
- R10: Reset drives `div_pulse` low and installs a low-band setting with word 0, so the block divides by 4 after reset until a new setting takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lo_clk | input | 1 | Local-oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit | input | 1 | Holds the divider in its load state with the output low |
| ref_tick | input | 1 | One-cycle strobe per reference period, synchronous to `lo_clk` |
| hi_band_sel | input | 1 | 1 selects the halved high-band path |
| swallow_sel | input | 1 | With `hi_band_sel`=0: 1 selects the mid-band swallow path, 0 selects the low-band counter |
| div_word | input | 16 | Binary divisor, bit 15 most significant |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |

## Verification
The divider is driven through all three paths with words chosen to separate the cases:

- **Swallow extremes:** words whose swallow part is 0 and 15 distinguish 16·M+A from other ways of splitting the word.
- **Low nibble:** low-band words that differ only in the bottom nibble show that those bits are ignored.
- **Clamping:** words below each minimum show the clamp in all three paths.

Setting changes are placed between reference ticks, and a second change is placed before the second tick, which separates a one-tick delay from a two-tick delay and shows that the wait restarts. A change made mid-period shows that the period in flight keeps its old length. An inhibit window followed by release checks the restart spacing. A behavioural model running alongside the design compares the output on every cycle.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int WORD_W = 16;
    localparam int SWL_W  = 4;
    localparam int MAIN_W = WORD_W - SWL_W;
    localparam int PRE_W  = SWL_W + 1;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'd0,
        MODE_MID  = 2'd1,
        MODE_HIGH = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [WORD_W-1:0]  word;
    } cfg_t;

    typedef struct packed {
        mode_e              mode;
        logic [PRE_W-1:0]   pre;
        logic [SWL_W-1:0]   swl;
        logic [MAIN_W-1:0]  main;
    } load_t;
endpackage

// File: rtl/fdiv_stage.sv
module fdiv_stage
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  cfg_t cfg_in,
    output cfg_t act_cfg
);
    typedef struct packed {
        cfg_t pend;
        logic armed;
        cfg_t act;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_in != st_q.pend) begin
            st_d.pend  = cfg_in;
            st_d.armed = 1'b0;
        end else if (ref_tick && (st_q.pend != st_q.act)) begin
            if (st_q.armed) begin
                st_d.act   = st_q.pend;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: '{mode: MODE_LOW, word: '0}, armed: 1'b0,
                      act:  '{mode: MODE_LOW, word: '0}};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
endmodule

// File: rtl/fdiv_load.sv
module fdiv_load
    import fdiv_pkg::*;
#(
    parameter int MIN_SWALLOW = 272,
    parameter int MIN_DIRECT  = 4
) (
    input  cfg_t  cfg,
    output load_t ld
);
    localparam logic [WORD_W-1:0] SW_MIN  = WORD_W'(MIN_SWALLOW);
    localparam logic [MAIN_W-1:0] DIR_MIN = MAIN_W'(MIN_DIRECT);
    localparam logic [PRE_W-1:0]  PRE_TOP = PRE_W'(1 << SWL_W);
    localparam logic [PRE_W-1:0]  PRE_LOW = PRE_W'((1 << SWL_W) - 1);

    logic [WORD_W-1:0] sw_word;
    logic [MAIN_W-1:0] dir_word;

    always_comb begin
        sw_word  = (cfg.word < SW_MIN) ? SW_MIN : cfg.word;
        dir_word = (cfg.word[WORD_W-1:SWL_W] < DIR_MIN) ? DIR_MIN
                                                        : cfg.word[WORD_W-1:SWL_W];
        ld.mode = cfg.mode;
        if (cfg.mode == MODE_LOW) begin
            ld.main = dir_word;
            ld.swl  = '0;
            ld.pre  = '0;
        end else begin
            ld.main = sw_word[WORD_W-1:SWL_W];
            ld.swl  = sw_word[SWL_W-1:0];
            ld.pre  = (sw_word[SWL_W-1:0] != '0) ? PRE_TOP : PRE_LOW;
        end
    end
endmodule

// File: rtl/fdiv_engine.sv
module fdiv_engine
    import fdiv_pkg::*;
#(
    parameter int MIN_DIRECT = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  inhibit,
    input  load_t ld,
    output logic  div_pulse
);
    localparam logic [PRE_W-1:0]  PRE_TOP = PRE_W'(1 << SWL_W);
    localparam logic [PRE_W-1:0]  PRE_LOW = PRE_W'((1 << SWL_W) - 1);
    localparam logic [PRE_W-1:0]  PRE_ONE = PRE_W'(1);
    localparam logic [SWL_W-1:0]  SWL_ONE = SWL_W'(1);
    localparam logic [MAIN_W-1:0] MAIN_ONE = MAIN_W'(1);

    typedef struct packed {
        mode_e              mode;
        logic               half;
        logic [PRE_W-1:0]   pre;
        logic [SWL_W-1:0]   swl;
        logic [MAIN_W-1:0]  main;
        logic               pulse;
    } eng_t;

    eng_t e_d, e_q;
    logic ev, cyc_done;
    logic [SWL_W-1:0] swl_nx;

    always_comb begin
        e_d      = e_q;
        e_d.pulse = 1'b0;
        ev       = (e_q.mode == MODE_HIGH) ? e_q.half : 1'b1;
        cyc_done = (e_q.mode == MODE_LOW) || (e_q.pre == '0);
        swl_nx   = (e_q.swl != '0) ? e_q.swl - SWL_ONE : '0;
        if (inhibit) begin
            e_d.mode = ld.mode;
            e_d.half = 1'b0;
            e_d.pre  = ld.pre;
            e_d.swl  = ld.swl;
            e_d.main = ld.main;
        end else begin
            e_d.half = (e_q.mode == MODE_HIGH) ? ~e_q.half : 1'b0;
            if (ev) begin
                if (!cyc_done) begin
                    e_d.pre = e_q.pre - PRE_ONE;
                end else if (e_q.main == MAIN_ONE) begin
                    e_d.pulse = 1'b1;
                    e_d.mode  = ld.mode;
                    e_d.pre   = ld.pre;
                    e_d.swl   = ld.swl;
                    e_d.main  = ld.main;
                end else begin
                    e_d.main = e_q.main - MAIN_ONE;
                    e_d.swl  = swl_nx;
                    if (e_q.mode == MODE_LOW) e_d.pre = '0;
                    else e_d.pre = (swl_nx != '0) ? PRE_TOP : PRE_LOW;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{mode: MODE_LOW, half: 1'b0, pre: '0, swl: '0,
                     main: MAIN_W'(MIN_DIRECT), pulse: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign div_pulse = e_q.pulse;
endmodule

// File: rtl/lo_feedback_divider.sv
module lo_feedback_divider
    import fdiv_pkg::*;
#(
    parameter int MIN_SWALLOW = 272,
    parameter int MIN_DIRECT  = 4
) (
    input  logic              lo_clk,
    input  logic              rst_n,
    input  logic              inhibit,
    input  logic              ref_tick,
    input  logic              hi_band_sel,
    input  logic              swallow_sel,
    input  logic [WORD_W-1:0] div_word,
    output logic              div_pulse
);
    cfg_t  cfg_in, act_cfg;
    load_t ld;

    always_comb begin
        cfg_in.word = div_word;
        if (hi_band_sel)      cfg_in.mode = MODE_HIGH;
        else if (swallow_sel) cfg_in.mode = MODE_MID;
        else                  cfg_in.mode = MODE_LOW;
    end

    fdiv_stage u_stage (
        .clk      (lo_clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .cfg_in   (cfg_in),
        .act_cfg  (act_cfg)
    );

    fdiv_load #(.MIN_SWALLOW(MIN_SWALLOW), .MIN_DIRECT(MIN_DIRECT)) u_load (
        .cfg (act_cfg),
        .ld  (ld)
    );

    fdiv_engine #(.MIN_DIRECT(MIN_DIRECT)) u_engine (
        .clk       (lo_clk),
        .rst_n     (rst_n),
        .inhibit   (inhibit),
        .ld        (ld),
        .div_pulse (div_pulse)
    );
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
    import fdiv_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic inhibit,
    input logic ref_tick,
    input logic div_pulse,
    input cfg_t act_cfg
);
    // R9: inhibit silences the output from the next cycle
    assert_inhibit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !div_pulse) else $error("R9 pulse during inhibit");

    // R8: pulses are single cycles
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse) else $error("R8 pulse wider than one cycle");

    // R6: the active setting only moves on a reference tick
    assert_tick_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(act_cfg)) else $error("R6 setting changed without tick");

    // R10: output held low in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!div_pulse) else $error("R10 pulse in reset");
        end
    end
endmodule

bind lo_feedback_divider fdiv_checker u_fdiv_chk (
    .clk       (lo_clk),
    .rst_n     (rst_n),
    .inhibit   (inhibit),
    .ref_tick  (ref_tick),
    .div_pulse (div_pulse),
    .act_cfg   (act_cfg)
);

// File: tb/lo_feedback_divider_bench.sv
`timescale 1ns/1ps
module lo_feedback_divider_bench;
    localparam int TICK_PER = 50;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inhibit = 1'b0;
    logic        ref_tick = 1'b0;
    logic        hi_band_sel = 1'b0;
    logic        swallow_sel = 1'b0;
    logic [15:0] div_word = 16'h0000;
    logic        div_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tick_cnt = 0;
    string phase = "R10";

    always #2.5 clk = ~clk;

    lo_feedback_divider u_lo_feedback_divider (
        .lo_clk(clk), .rst_n(rst_n), .inhibit(inhibit), .ref_tick(ref_tick),
        .hi_band_sel(hi_band_sel), .swallow_sel(swallow_sel),
        .div_word(div_word), .div_pulse(div_pulse)
    );

    // reference tick source
    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == TICK_PER - 1) ? 0 : tick_cnt + 1;
        ref_tick <= (tick_cnt == TICK_PER - 1);
    end

    // behavioural model: modes 0 low, 1 mid, 2 high; rem counts input events
    int pend_w = 0, pend_m = 0, act_w = 0, act_m = 0, cur_m = 0, rem = 4;
    int nw, nm;
    bit armed = 0, half = 0, ev, m_pulse = 0;

    function automatic int neff(int m, int w);
        int d;
        if (m != 0) return (w < 272) ? 272 : w;
        d = w >> 4;
        return (d < 4) ? 4 : d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend_w = 0; pend_m = 0; act_w = 0; act_m = 0; armed = 0;
            cur_m = 0; rem = 4; half = 0; m_pulse = 0;
        end else begin
            if (inhibit) begin
                cur_m = act_m; rem = neff(act_m, act_w); half = 0; m_pulse = 0;
            end else begin
                ev = (cur_m == 2) ? half : 1'b1;
                half = (cur_m == 2) ? !half : 1'b0;
                m_pulse = 0;
                if (ev) begin
                    if (rem == 1) begin
                        m_pulse = 1; cur_m = act_m; rem = neff(act_m, act_w);
                    end else rem = rem - 1;
                end
            end
            nw = int'(div_word);
            nm = hi_band_sel ? 2 : (swallow_sel ? 1 : 0);
            if (nw != pend_w || nm != pend_m) begin
                pend_w = nw; pend_m = nm; armed = 0;
            end else if (ref_tick && (pend_w != act_w || pend_m != act_m)) begin
                if (armed) begin act_w = pend_w; act_m = pend_m; armed = 0; end
                else armed = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (div_pulse !== m_pulse) begin
                failures++;
                $display("FAIL %s cycle %0d model compare actual=%0b expected=%0b",
                         phase, cyc, div_pulse, m_pulse);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            failures++;
            $display("FAIL %s watchdog actual=%0d expected<%0d", phase, cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk); #1;
    endtask

    task automatic wait_pulse;
        do step(); while (!div_pulse);
    endtask

    task automatic wait_tick;
        do step(); while (!ref_tick);
        step();
    endtask

    task automatic measure(output int n);
        wait_pulse();
        n = 0;
        do begin step(); n++; end while (!div_pulse);
    endtask

    task automatic setcfg(input bit h, input bit s, input logic [15:0] w);
        hi_band_sel = h; swallow_sel = s; div_word = w;
        repeat (3 * TICK_PER) step();
        wait_pulse();
    endtask

    initial begin
        int n, hits;
        bit dbl;
        repeat (4) step();
        chk("R10 output low in reset", div_pulse, 0);
        step();
        rst_n = 1'b1;
        phase = "R10";
        measure(n);
        chk("R10 divide by 4 after reset", n, 4);

        phase = "R8";
        hits = 0; dbl = 0;
        for (int i = 0; i < 40; i++) begin
            bit prev;
            prev = div_pulse;
            step();
            if (div_pulse) hits++;
            if (prev && div_pulse) dbl = 1;
        end
        chk("R8 pulses per 40 cycles at N=4", hits, 10);
        chk("R8 no back-to-back pulse", dbl, 0);

        phase = "R6";
        wait_tick();
        div_word = 16'h0915;
        wait_tick();
        measure(n);
        chk("R6 old divisor kept after first tick", n, 4);
        wait_tick();
        wait_pulse();
        measure(n);
        chk("R3 low band uses bits 15:4", n, 145);

        phase = "R3";
        setcfg(0, 0, 16'h091F);
        measure(n);
        chk("R3 low nibble ignored", n, 145);
        phase = "R5";
        setcfg(0, 0, 16'h0020);
        measure(n);
        chk("R5 low band clamp to 4", n, 4);

        phase = "R2";
        setcfg(0, 1, 16'd4440);
        measure(n);
        chk("R2 mid band divide by word", n, 4440);
        phase = "R4";
        setcfg(0, 1, 16'h111F);
        measure(n);
        chk("R4 swallow A=15", n, 4383);
        setcfg(0, 1, 16'h1200);
        measure(n);
        chk("R4 swallow A=0", n, 4608);
        phase = "R5";
        setcfg(0, 1, 16'd100);
        measure(n);
        chk("R5 mid band clamp to 272", n, 272);

        phase = "R1";
        setcfg(1, 0, 16'd2014);
        measure(n);
        chk("R1 high band doubles divisor", n, 4028);
        setcfg(1, 1, 16'd2014);
        measure(n);
        chk("R1 high select overrides swallow select", n, 4028);
        phase = "R5";
        setcfg(1, 0, 16'd5);
        measure(n);
        chk("R5 high band clamp to 2x272", n, 544);

        phase = "R6";
        setcfg(0, 0, 16'h0040);
        wait_tick();
        div_word = 16'h0910;
        wait_tick();
        div_word = 16'h0500;
        wait_tick();
        measure(n);
        chk("R6 second change restarts wait", n, 4);
        wait_tick();
        wait_pulse();
        measure(n);
        chk("R6 restaged word applied", n, 80);

        phase = "R7";
        setcfg(0, 1, 16'd4440);
        wait_pulse();
        div_word = 16'd272;
        n = 0;
        do begin step(); n++; end while (!div_pulse);
        chk("R7 period in flight keeps old divisor", n, 4440);
        n = 0;
        do begin step(); n++; end while (!div_pulse);
        chk("R7 next period uses new divisor", n, 272);

        phase = "R9";
        setcfg(0, 0, 16'h0910);
        inhibit = 1'b1;
        step();
        hits = 0;
        for (int i = 0; i < 400; i++) begin
            step();
            if (div_pulse) hits++;
        end
        chk("R9 no pulse while inhibited", hits, 0);
        inhibit = 1'b0;
        n = 0;
        do begin step(); n++; end while (!div_pulse);
        chk("R9 first pulse one period after release", n, 145);
        measure(n);
        chk("R9 steady period after release", n, 145);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule